// File: doc/BRIEF.md
# Four-Port USB PHY Power Sequencer

This block brings four USB PHY ports (the device port, the host port and two HSIC ports) up and down in hardware. Each port has a one-cycle on pulse and a one-cycle off pulse. The sequencer keeps a count of external users and a count of internal users for each port. It drives the PHY power-down word, the PHY reset word, three isolation enables and a device/host mode select. It also loads a three-bit reference-clock select from a rate given in kHz.

Ports depend on one another. A host port needs the device PHY, and an HSIC port needs both the device PHY and the host PHY. The sequencer powers those dependencies on and off itself, in a fixed order. Each real power-up does the following in order:
- releases isolation;
- clears the port's power-down bits;
- asserts its reset bits for a timed interval;
- releases reset;
- waits a timed settle interval before the port reports ready.

Both intervals are counted in clock cycles, worked out from a clock-frequency parameter.

Top module: `usb_phy_pwr_seq`

## Requirements
- R1: After reset the outputs are as follows. `pwrdn_ctl` is 0x7FF9. `rst_ctl` is 0. `iso_en` is 3'b111. `mode_host` is 1. `port_ready`, `underflow_err`, `freq_sel` and `rate_err` are all 0.
- R2: A real power-up of a port happens on one clock edge, in the cycle after the port is selected. On that edge it loads `freq_sel` (when the rate is known), releases the port's isolation, clears its power-down bits and sets its reset bits. The reset bits are released later, and `port_ready` rises only with reset and power-down clear for that port.
- R3: A real power-down of a port happens on a single edge. That edge sets the port's isolation and its power-down bits and clears its `port_ready`. It leaves `rst_ctl` unchanged.
- R4: Each port has an external count and an internal count. Hardware actions happen only when the internal count goes from 0 to 1 or from 1 to 0. An on or off request that does not cross zero in the external count only changes the counts.
- R5: A host power-on from zero users has this order. It first sets `mode_host` to 1. It then takes the device PHY, then the host PHY.
- R6: An HSIC power-on from zero users takes the device PHY, then the host PHY, then the HSIC port itself. The last HSIC power-off releases them in that same order.
- R7: A device power-on from zero users sets `mode_host` to 0. The last device power-off sets it back to 1.
- R8: The power-down bits of each port are:
  - device: bits 0, 3, 4 and 5;
  - host: bits 6 to 8;
  - HSIC0: bits 9 to 11;
  - HSIC1: bits 12 to 14.

  The reset bits of each port are:
  - device: bit 0;
  - host: bits 3, 4 and 10;
  - HSIC0: bits 6 and 9;
  - HSIC1: bits 5 and 9.

  The isolation bits are:
  - bit 0 is shared by the device and host ports;
  - bit 1 is for HSIC0;
  - bit 2 is for HSIC1.
- R9: The rate codes are 9600→0, 10000→1, 12000→2, 19200→3, 20000→4, 24000→5 and 50000→7. `rate_err` is registered every cycle and is high when `ref_rate_khz` is not one of these. For an unknown rate, `freq_sel` is not loaded.
- R10: Each port holds one pending request, and a later request replaces it. If on and off arrive together, on wins. Pending requests are served one at a time, lowest port index first.
- R11: An off request for a port whose external count is zero is ignored. It sets that port's `underflow_err` bit, which stays set until reset.
- R12: The reset bits stay high for ceil(RST_US·CLK_KHZ/1000) cycles. `port_ready` rises ceil(SETTLE_US·CLK_KHZ/1000) cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| on_req | input | 4 | One-cycle power-on request per port (device, host, HSIC0, HSIC1) |
| off_req | input | 4 | One-cycle power-off request per port |
| ref_rate_khz | input | RATE_W | Reference clock rate in kHz |
| pwrdn_ctl | output | 15 | PHY power-down control word |
| rst_ctl | output | 11 | PHY reset control word |
| iso_en | output | 3 | Isolation enables (shared device/host, HSIC0, HSIC1) |
| mode_host | output | 1 | 1 selects host mode, 0 selects device mode |
| port_ready | output | 4 | Port powered and settled |
| underflow_err | output | 4 | Sticky off-request underflow flags |
| freq_sel | output | 3 | Reference-clock frequency select code |
| rate_err | output | 1 | Reference rate not recognised |

## Verification
Timing is counted from the clock edge that first sees a request pulse, where the request is registered as pending:
- the count and mode-select update lands on the next edge, when the request is selected;
- each step through the dependency chain takes one further edge;
- on a real power-up, reset falls RST_CYC edges after the step edge, and `port_ready` rises SETTLE_CYC edges after that;
- `rate_err` follows the rate input by one edge.

The bench model advances edge by edge along the same schedule, and it updates its expected values on the same edge as the design. Outputs are compared on the falling edge, so each value is read half a cycle after the edge that set it. Order-sensitive results are checked from the cycles at which each ready flag rose, and the length of the reset pulse from a run-length count.

// File: rtl/usb_phy_seq_pkg.sv
package usb_phy_seq_pkg;
  localparam int NPORT = 4;
  localparam int PWR_W = 15;
  localparam int RST_W = 11;
  localparam int ISO_W = 3;

  typedef logic [1:0] port_t;
  typedef enum logic [1:0] {ST_IDLE, ST_STEP, ST_HOLD, ST_SETTLE} seq_st_e;

  // power-down bit group of a port
  function automatic logic [PWR_W-1:0] pwr_mask(input port_t p);
    case (p)
      2'd0:    pwr_mask = 15'h0039;
      2'd1:    pwr_mask = 15'h01C0;
      2'd2:    pwr_mask = 15'h0E00;
      default: pwr_mask = 15'h7000;
    endcase
  endfunction

  // reset bit group of a port
  function automatic logic [RST_W-1:0] rst_mask(input port_t p);
    case (p)
      2'd0:    rst_mask = 11'h001;
      2'd1:    rst_mask = 11'h418;
      2'd2:    rst_mask = 11'h240;
      default: rst_mask = 11'h220;
    endcase
  endfunction

  // device and host share one isolation enable
  function automatic logic [1:0] iso_idx(input port_t p);
    iso_idx = (p < 2'd2) ? 2'd0 : (p - 2'd1);
  endfunction

  // number of ports touched when a port is requested
  function automatic logic [1:0] chain_len(input port_t p);
    case (p)
      2'd0:    chain_len = 2'd1;
      2'd1:    chain_len = 2'd2;
      default: chain_len = 2'd3;
    endcase
  endfunction

  // chain order: device, host, then the port itself
  function automatic port_t chain_tgt(input port_t p, input logic [1:0] idx);
    if (idx == 2'd0)      chain_tgt = 2'd0;
    else if (idx == 2'd1) chain_tgt = 2'd1;
    else                  chain_tgt = p;
  endfunction
endpackage

// File: rtl/usb_phy_rate_decode.sv
module usb_phy_rate_decode #(
  parameter int RATE_W = 16
) (
  input  logic [RATE_W-1:0] rate_khz,
  output logic [2:0]        code,
  output logic              known
);
  always_comb begin
    known = 1'b1;
    code  = 3'd0;
    if (rate_khz == RATE_W'(9600))       code = 3'd0;
    else if (rate_khz == RATE_W'(10000)) code = 3'd1;
    else if (rate_khz == RATE_W'(12000)) code = 3'd2;
    else if (rate_khz == RATE_W'(19200)) code = 3'd3;
    else if (rate_khz == RATE_W'(20000)) code = 3'd4;
    else if (rate_khz == RATE_W'(24000)) code = 3'd5;
    else if (rate_khz == RATE_W'(50000)) code = 3'd7;
    else                                 known = 1'b0;
  end
endmodule

// File: rtl/usb_phy_req_queue.sv
module usb_phy_req_queue #(
  parameter int NPORT = 4,
  localparam int IDX_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] on_req,
  input  logic [NPORT-1:0] off_req,
  input  logic [NPORT-1:0] clr,
  output logic             pend_any,
  output logic [IDX_W-1:0] pick_idx,
  output logic             pick_on
);
  logic [NPORT-1:0] pend_q;
  logic [NPORT-1:0] dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      dir_q  <= '0;
    end else begin
      for (int i = 0; i < NPORT; i++) begin
        if (on_req[i] || off_req[i]) begin
          pend_q[i] <= 1'b1;
          dir_q[i]  <= on_req[i];
        end else if (clr[i]) begin
          pend_q[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    pick_idx = '0;
    for (int i = NPORT - 1; i >= 0; i--) begin
      if (pend_q[i]) pick_idx = IDX_W'(i);
    end
  end

  assign pend_any = |pend_q;
  assign pick_on  = dir_q[pick_idx];

  // R10: at most one port is served at a time, and only a pending one
  p_clr_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr) && ((clr & ~pend_q) == '0));
endmodule

// File: rtl/usb_phy_delay_timer.sv
module usb_phy_delay_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R12: a running count only ever moves down by one
  p_count_down_r12: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/usb_phy_pwr_seq.sv
module usb_phy_pwr_seq
  import usb_phy_seq_pkg::*;
#(
  parameter int CLK_KHZ   = 50000,
  parameter int RST_US    = 10,
  parameter int SETTLE_US = 80,
  parameter int RATE_W    = 16,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        on_req,
  input  logic [3:0]        off_req,
  input  logic [RATE_W-1:0] ref_rate_khz,
  output logic [14:0]       pwrdn_ctl,
  output logic [10:0]       rst_ctl,
  output logic [2:0]        iso_en,
  output logic              mode_host,
  output logic [3:0]        port_ready,
  output logic [3:0]        underflow_err,
  output logic [2:0]        freq_sel,
  output logic              rate_err
);
  localparam int RST_RAW = (RST_US * CLK_KHZ + 999) / 1000;
  localparam int SET_RAW = (SETTLE_US * CLK_KHZ + 999) / 1000;
  localparam int RST_CYC = (RST_RAW < 1) ? 1 : RST_RAW;
  localparam int SET_CYC = (SET_RAW < 1) ? 1 : SET_RAW;
  localparam int MAX_CYC = (RST_CYC > SET_CYC) ? RST_CYC : SET_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);
  localparam logic [14:0] PWR_ALL = 15'h7FF9;

  seq_st_e          st;
  port_t            cur_p;
  logic             cur_on;
  logic [1:0]       idx;
  logic [CNT_W-1:0] ext_cnt [NPORT];
  logic [CNT_W-1:0] int_cnt [NPORT];

  logic             pend_any, pick_on;
  port_t            pick_idx;
  logic [NPORT-1:0] clr;
  logic [2:0]       rate_code;
  logic             rate_ok;
  logic             tmr_load, tmr_done;
  logic [TMR_W-1:0] tmr_val;
  port_t            tgt;
  logic             at_last;
  logic             hw_up;

  usb_phy_req_queue #(.NPORT(NPORT)) u_queue (
    .clk(clk), .rst(rst), .on_req(on_req), .off_req(off_req), .clr(clr),
    .pend_any(pend_any), .pick_idx(pick_idx), .pick_on(pick_on));

  usb_phy_rate_decode #(.RATE_W(RATE_W)) u_rate (
    .rate_khz(ref_rate_khz), .code(rate_code), .known(rate_ok));

  usb_phy_delay_timer #(.CNT_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done));

  assign tgt     = chain_tgt(cur_p, idx);
  assign at_last = (idx == chain_len(cur_p) - 2'd1);
  assign hw_up   = (st == ST_STEP) && cur_on && (int_cnt[tgt] == '0);
  assign clr     = (st == ST_IDLE && pend_any) ? (NPORT'(1) << pick_idx) : '0;
  assign tmr_load = hw_up || (st == ST_HOLD && tmr_done);
  assign tmr_val  = (st == ST_HOLD) ? TMR_W'(SET_CYC - 1) : TMR_W'(RST_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      cur_p         <= '0;
      cur_on        <= 1'b0;
      idx           <= '0;
      pwrdn_ctl     <= PWR_ALL;
      rst_ctl       <= '0;
      iso_en        <= '1;
      mode_host     <= 1'b1;
      port_ready    <= '0;
      underflow_err <= '0;
      freq_sel      <= '0;
      rate_err      <= 1'b0;
      for (int i = 0; i < NPORT; i++) begin
        ext_cnt[i] <= '0;
        int_cnt[i] <= '0;
      end
    end else begin
      rate_err <= !rate_ok;
      case (st)
        ST_IDLE: begin
          if (pend_any) begin
            cur_p  <= pick_idx;
            cur_on <= pick_on;
            idx    <= '0;
            if (pick_on) begin
              ext_cnt[pick_idx] <= ext_cnt[pick_idx] + 1'b1;
              if (ext_cnt[pick_idx] == '0) begin
                if (pick_idx == 2'd0) mode_host <= 1'b0;
                if (pick_idx == 2'd1) mode_host <= 1'b1;
                st <= ST_STEP;
              end
            end else if (ext_cnt[pick_idx] == '0) begin
              underflow_err[pick_idx] <= 1'b1;
            end else begin
              ext_cnt[pick_idx] <= ext_cnt[pick_idx] - 1'b1;
              if (ext_cnt[pick_idx] == CNT_W'(1)) begin
                if (pick_idx == 2'd0) mode_host <= 1'b1;
                st <= ST_STEP;
              end
            end
          end
        end
        ST_STEP: begin
          if (cur_on) begin
            int_cnt[tgt] <= int_cnt[tgt] + 1'b1;
            if (int_cnt[tgt] == '0) begin
              if (rate_ok) freq_sel <= rate_code;
              iso_en[iso_idx(tgt)] <= 1'b0;
              pwrdn_ctl <= pwrdn_ctl & ~pwr_mask(tgt);
              rst_ctl   <= rst_ctl | rst_mask(tgt);
              st        <= ST_HOLD;
            end else if (at_last) begin
              st <= ST_IDLE;
            end else begin
              idx <= idx + 2'd1;
            end
          end else begin
            if (int_cnt[tgt] != '0) int_cnt[tgt] <= int_cnt[tgt] - 1'b1;
            if (int_cnt[tgt] == CNT_W'(1)) begin
              iso_en[iso_idx(tgt)] <= 1'b1;
              pwrdn_ctl       <= pwrdn_ctl | pwr_mask(tgt);
              port_ready[tgt] <= 1'b0;
            end
            if (at_last) st <= ST_IDLE;
            else         idx <= idx + 2'd1;
          end
        end
        ST_HOLD: begin
          if (tmr_done) begin
            rst_ctl <= rst_ctl & ~rst_mask(tgt);
            st      <= ST_SETTLE;
          end
        end
        default: begin
          if (tmr_done) begin
            port_ready[tgt] <= 1'b1;
            if (at_last) st <= ST_IDLE;
            else begin
              idx <= idx + 2'd1;
              st  <= ST_STEP;
            end
          end
        end
      endcase
    end
  end

  // R2: reset is held for the whole timed pulse
  p_hold_has_rst_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD) |-> (rst_ctl != '0));

  // R7: mode select only moves when a request is taken
  p_mode_on_take_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_host) |-> ($past(st) == ST_IDLE));

  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_chk
      // R2: ready appears only on a powered, released, de-isolated port
      p_ready_clean_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(port_ready[g]) |->
          (((rst_ctl & rst_mask(2'(g))) == '0) &&
           ((pwrdn_ctl & pwr_mask(2'(g))) == '0) && !iso_en[iso_idx(2'(g))]));
      // R3: power-off isolates and powers down without any reset change
      p_off_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(port_ready[g]) |->
          (((pwrdn_ctl & pwr_mask(2'(g))) == pwr_mask(2'(g))) &&
           iso_en[iso_idx(2'(g))] && $stable(rst_ctl)));
      // R11: underflow flag is sticky
      p_uf_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        underflow_err[g] |=> underflow_err[g]);
    end
  endgenerate
endmodule

// File: tb/tb_usb_phy_pwr_seq.sv
`timescale 1ns/1ps
module tb_usb_phy_pwr_seq;
  localparam int CLK_KHZ = 1000;
  localparam int RST_N   = 10;
  localparam int SET_N   = 80;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  on_req = '0, off_req = '0;
  logic [15:0] ref_rate_khz = 16'd24000;
  logic [14:0] pwrdn_ctl;
  logic [10:0] rst_ctl;
  logic [2:0]  iso_en, freq_sel;
  logic        mode_host, rate_err;
  logic [3:0]  port_ready, underflow_err;

  usb_phy_pwr_seq #(.CLK_KHZ(CLK_KHZ), .RST_US(10), .SETTLE_US(80)) dut (
    .clk(clk), .rst(rst), .on_req(on_req), .off_req(off_req),
    .ref_rate_khz(ref_rate_khz), .pwrdn_ctl(pwrdn_ctl), .rst_ctl(rst_ctl),
    .iso_en(iso_en), .mode_host(mode_host), .port_ready(port_ready),
    .underflow_err(underflow_err), .freq_sel(freq_sel), .rate_err(rate_err));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [14:0] e_pwr;
  logic [10:0] e_rst;
  logic [2:0]  e_iso, e_freq;
  logic        e_mode, e_rerr;
  logic [3:0]  e_rdy, e_uf;
  bit   m_pend [4];
  bit   m_on   [4];
  int   ext    [4];
  int   use_n  [4];

  function automatic logic [14:0] b_pwr(int p);
    logic [14:0] v = '0;
    case (p)
      0: begin v[0] = 1; v[3] = 1; v[4] = 1; v[5] = 1; end
      1: begin v[6] = 1; v[7] = 1; v[8] = 1; end
      2: begin v[9] = 1; v[10] = 1; v[11] = 1; end
      default: begin v[12] = 1; v[13] = 1; v[14] = 1; end
    endcase
    return v;
  endfunction
  function automatic logic [10:0] b_rst(int p);
    logic [10:0] v = '0;
    case (p)
      0: v[0] = 1;
      1: begin v[3] = 1; v[4] = 1; v[10] = 1; end
      2: begin v[6] = 1; v[9] = 1; end
      default: begin v[5] = 1; v[9] = 1; end
    endcase
    return v;
  endfunction
  function automatic int rate_code(input logic [15:0] r);
    case (r)
      16'd9600: return 0;  16'd10000: return 1; 16'd12000: return 2;
      16'd19200: return 3; 16'd20000: return 4; 16'd24000: return 5;
      16'd50000: return 7;
      default: return -1;
    endcase
  endfunction

  task automatic model_reset();
    e_pwr = 15'h7FF9; e_rst = '0; e_iso = 3'b111; e_mode = 1; e_rdy = '0;
    e_uf = '0; e_freq = '0; e_rerr = 0;
    for (int i = 0; i < 4; i++) begin m_pend[i] = 0; m_on[i] = 0; ext[i] = 0; use_n[i] = 0; end
  endtask
  task automatic capture();
    e_rerr = (rate_code(ref_rate_khz) < 0);
    for (int i = 0; i < 4; i++) begin
      if (on_req[i])       begin m_pend[i] = 1; m_on[i] = 1; end
      else if (off_req[i]) begin m_pend[i] = 1; m_on[i] = 0; end
    end
  endtask
  task automatic tick();
    @(posedge clk);
    capture();
  endtask
  task automatic walk(input int p, input bit up);
    int list[$];
    list.push_back(0);
    if (p >= 1) list.push_back(1);
    if (p >= 2) list.push_back(p);
    foreach (list[k]) begin
      int t = list[k];
      int ii = (t < 2) ? 0 : t - 1;
      tick();
      if (up) begin
        use_n[t]++;
        if (use_n[t] == 1) begin
          if (rate_code(ref_rate_khz) >= 0) e_freq = 3'(rate_code(ref_rate_khz));
          e_iso[ii] = 0; e_pwr &= ~b_pwr(t); e_rst |= b_rst(t);
          repeat (RST_N) tick();
          e_rst &= ~b_rst(t);
          repeat (SET_N) tick();
          e_rdy[t] = 1;
        end
      end else begin
        if (use_n[t] == 1) begin
          e_iso[ii] = 1; e_pwr |= b_pwr(t); e_rdy[t] = 0;
        end
        if (use_n[t] > 0) use_n[t]--;
      end
    end
  endtask
  task automatic serve(input int p, input bit up);
    if (up) begin
      ext[p]++;
      if (ext[p] == 1) begin
        if (p == 0) e_mode = 0;
        if (p == 1) e_mode = 1;
        walk(p, 1);
      end
    end else if (ext[p] == 0) begin
      e_uf[p] = 1;
    end else begin
      ext[p]--;
      if (ext[p] == 0) begin
        if (p == 0) e_mode = 1;
        walk(p, 0);
      end
    end
  endtask

  initial begin
    model_reset();
    forever begin
      int sel;
      bit up;
      @(posedge clk);
      if (rst) begin model_reset(); continue; end
      sel = -1; up = 0;
      for (int i = 3; i >= 0; i--) if (m_pend[i]) sel = i;
      if (sel >= 0) begin m_pend[sel] = 0; up = m_on[sel]; end
      capture();
      if (sel >= 0) serve(sel, up);
    end
  end

  // ---------------- per-cycle comparison and monitors ----------------
  int cyc = 0, rst_run = 0, last_run = 0;
  int rise_at [4];
  logic [3:0] rdy_prev = '0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(pwrdn_ctl == e_pwr, "R8 pwrdn", pwrdn_ctl, e_pwr);
      chk(rst_ctl == e_rst, "R2 rst", rst_ctl, e_rst);
      chk(iso_en == e_iso, "R3 iso", iso_en, e_iso);
      chk(mode_host == e_mode, "R7 mode", mode_host, e_mode);
      chk(port_ready == e_rdy, "R12 ready", port_ready, e_rdy);
      chk(underflow_err == e_uf, "R11 underflow", underflow_err, e_uf);
      chk(freq_sel == e_freq, "R9 freq", freq_sel, e_freq);
      chk(rate_err == e_rerr, "R9 rate_err", rate_err, e_rerr);
      for (int i = 0; i < 4; i++) if (port_ready[i] && !rdy_prev[i]) rise_at[i] = cyc;
      rdy_prev = port_ready;
      if (rst_ctl != '0) rst_run++;
      else if (rst_run > 0) begin last_run = rst_run; rst_run = 0; end
    end
  end

  task automatic pulse(input logic [3:0] onm, input logic [3:0] offm);
    @(negedge clk); on_req = onm; off_req = offm;
    @(negedge clk); on_req = '0; off_req = '0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int r_before;
    repeat (4) @(negedge clk);
    chk(pwrdn_ctl == 15'h7FF9 && rst_ctl == 0 && iso_en == 3'b111 && mode_host &&
        port_ready == 0 && underflow_err == 0, "R1 reset state", pwrdn_ctl, 15'h7FF9);
    rst = 0;
    idle(3);
    // device on
    pulse(4'b0001, 4'b0000);
    idle(120);
    chk(port_ready == 4'b0001 && !mode_host, "R7 device on", port_ready, 1);
    chk(last_run == RST_N, "R12 reset pulse length", last_run, RST_N);
    chk(freq_sel == 3'd5, "R9 code for 24000", freq_sel, 5);
    // extra on, extra off: counts only
    r_before = rise_at[0];
    pulse(4'b0001, 4'b0000); idle(20);
    pulse(4'b0000, 4'b0001); idle(20);
    chk(port_ready == 4'b0001 && rise_at[0] == r_before && rst_ctl == 0,
        "R4 no action on extra request", port_ready, 1);
    // last off
    pulse(4'b0000, 4'b0001); idle(20);
    chk(port_ready == 0 && mode_host && iso_en[0], "R3 device off", port_ready, 0);
    // underflow
    pulse(4'b0000, 4'b0001); idle(10);
    chk(underflow_err == 4'b0001 && pwrdn_ctl == 15'h7FF9, "R11 ignored off", underflow_err, 1);
    // host on
    pulse(4'b0010, 4'b0000); idle(240);
    chk(port_ready == 4'b0011 && mode_host && rise_at[0] < rise_at[1], "R5 host chain", port_ready, 3);
    // both HSIC on together
    pulse(4'b1100, 4'b0000); idle(240);
    chk(port_ready == 4'b1111, "R10 both HSIC up", port_ready, 15);
    chk(rise_at[2] < rise_at[3], "R10 lower index first", rise_at[2], rise_at[3]);
    // unknown rate
    @(negedge clk); ref_rate_khz = 16'd11111; idle(2);
    chk(rate_err == 1'b1, "R9 unknown rate", rate_err, 1);
    // tear down
    pulse(4'b0000, 4'b1000); idle(10);
    pulse(4'b0000, 4'b0100); idle(10);
    pulse(4'b0000, 4'b0010); idle(10);
    chk(port_ready == 0 && pwrdn_ctl == 15'h7FF9 && iso_en == 3'b111, "R6 all released", port_ready, 0);
    // HSIC1 from cold at 19.2 MHz
    @(negedge clk); ref_rate_khz = 16'd19200;
    pulse(4'b1000, 4'b0000); idle(320);
    chk(rise_at[0] < rise_at[1] && rise_at[1] < rise_at[3], "R6 dependency order", rise_at[1], rise_at[3]);
    chk(pwrdn_ctl == 15'h0E00 && rst_ctl == 0, "R8 bit groups", pwrdn_ctl, 15'h0E00);
    chk(freq_sel == 3'd3 && !rate_err, "R9 code for 19200", freq_sel, 3);
    chk(last_run == RST_N, "R2 reset released after pulse", last_run, RST_N);
    // HSIC1 off releases device, host, HSIC1
    pulse(4'b0000, 4'b1000); idle(10);
    chk(port_ready == 0 && pwrdn_ctl == 15'h7FF9, "R3 HSIC off", port_ready, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule